// File: doc/BRIEF.md
# Condition Register and Branch Decision Unit

This block keeps the condition state and the loop counter that a processor's branch stage consults. It holds a condition register built from eight 4-bit fields and a word-wide count register. On request it compares two words, or a word against a 16-bit immediate, as signed or unsigned values, and writes the outcome into one chosen field. Separately, an arithmetic or logical result marked for recording is compared with zero and written into field 0.

Each cycle a branch request with a mode, a condition bit index and a required sense yields a combinational taken decision. Some modes decrement the count register at the clock edge and test its new value against zero, alone or together with a condition bit. The count register is loaded from a general-register value and can always be read back. Target computation and instruction fetch belong to other blocks.

Top module: `cr_branch_unit`

## Requirements
- R1: After reset, `cr_value`, `ctr_value` and `br_taken` are all zero.
- R2: Field f occupies `cr_value[CRW-1-4f -: 4]`, so field 0 is the most significant nibble. Inside a field the bits from most to least significant are less-than, greater-than, equal and summary-overflow. A register-form compare sets exactly one of the first three, one clock after `cmp_valid`. With `cmp_signed`=1 the operands are two's complement.
- R3: With `cmp_signed`=0 the compare treats both operands as unsigned.
- R4: With `cmp_use_imm`=1 the second operand is `cmp_imm`. A signed compare sign-extends it and an unsigned compare zero-extends it.
- R5: A compare or record write changes only the field it targets. All other fields keep their values.
- R6: `rec_valid` writes field 0 with the signed comparison of `rec_result` against zero. When a compare targets field 0 in the same cycle, the compare result is written instead.
- R7: The summary-overflow bit of every written field copies `so_in` from the write cycle.
- R8: Condition bit n is `cr_value[CRW-1-n]`. The mode encoding is as follows:
  - Mode 0: taken when that bit equals `br_sense`.
  - Mode 1: always taken.
  - Modes 6 and 7: never taken.
  - `br_taken` is 0 whenever `br_valid` is 0.
- R9: Mode 2 decrements the count register at the clock edge and is taken when the count minus one is nonzero. The count wraps from 0 to all ones.
- R10: Mode 3 decrements in the same way and is taken when the count minus one is zero.
- R11: Modes 4 and 5 decrement like modes 2 and 3. They are taken only when the zero test passes and the condition bit equals `br_sense`. The decrement happens whether or not the branch is taken.
- R12: Branch requests never change `cr_value`. Modes 0, 1, 6 and 7 leave `ctr_value` unchanged.
- R13: `ctr_wr` loads `ctr_wdata` into the count register on the next edge. It wins over a decrement in the same cycle, whose decision still uses the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_use_imm | input | 1 | 1 = second operand is the immediate |
| cmp_field | input | 3 | Destination field index |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand (register form) |
| cmp_imm | input | 16 | Immediate operand |
| so_in | input | 1 | Sticky overflow copied into written fields |
| rec_valid | input | 1 | Record-form result present |
| rec_result | input | 32 | Result compared against zero into field 0 |
| br_valid | input | 1 | Branch request |
| br_mode | input | 3 | Branch mode (see R8 to R11) |
| br_bit | input | 5 | Condition bit index, 0 = most significant |
| br_sense | input | 1 | Required value of the condition bit |
| ctr_wr | input | 1 | Load count register |
| ctr_wdata | input | 32 | Count register load value |
| br_taken | output | 1 | Branch decision (combinational) |
| cr_value | output | 32 | Condition register contents |
| ctr_value | output | 32 | Count register contents |

## Verification
The bench builds the block with its defaults: a 32-bit word, eight fields and a 16-bit immediate. With those values the vectors can reach every field, including condition bit 31. They also reach the sign boundary between 0x7FFF_FFFF and 0x8000_0000 and the immediate extension boundary at 0x8000 and 0xFFFF. The count register can be walked from small loads through zero and the wrap to all ones within a few cycles.

// File: rtl/crb_pkg.sv
package crb_pkg;

  typedef enum logic [2:0] {
    BR_COND     = 3'd0,
    BR_ALWAYS   = 3'd1,
    BR_DNZ      = 3'd2,
    BR_DZ       = 3'd3,
    BR_DNZ_COND = 3'd4,
    BR_DZ_COND  = 3'd5,
    BR_RSV6     = 3'd6,
    BR_RSV7     = 3'd7
  } br_mode_e;

  localparam int FIELD_BITS = 4;

  // pack the relation flags in field order: LT, GT, EQ, SO
  function automatic logic [FIELD_BITS-1:0] make_nibble(input logic lt, input logic gt,
                                                        input logic eq, input logic so);
    return {lt, gt, eq, so};
  endfunction

  function automatic logic mode_decrements(input br_mode_e m);
    return (m == BR_DNZ) || (m == BR_DZ) || (m == BR_DNZ_COND) || (m == BR_DZ_COND);
  endfunction

  function automatic logic mode_wants_zero(input br_mode_e m);
    return (m == BR_DZ) || (m == BR_DZ_COND);
  endfunction

  function automatic logic mode_uses_bit(input br_mode_e m);
    return (m == BR_COND) || (m == BR_DNZ_COND) || (m == BR_DZ_COND);
  endfunction

endpackage

// File: rtl/crb_compare.sv
module crb_compare #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req,
  input  logic                             is_signed,
  input  logic                             use_imm,
  input  logic [XLEN-1:0]                  opa,
  input  logic [XLEN-1:0]                  opb,
  input  logic [IMMW-1:0]                  imm,
  input  logic                             so,
  output logic [crb_pkg::FIELD_BITS-1:0]   nib
);
  import crb_pkg::*;

  function automatic logic [XLEN-1:0] widen(input logic [IMMW-1:0] v, input logic sx);
    return sx ? {{(XLEN-IMMW){v[IMMW-1]}}, v} : {{(XLEN-IMMW){1'b0}}, v};
  endfunction

  function automatic logic less_than(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                     input logic sgn);
    return sgn ? ($signed(a) < $signed(b)) : (a < b);
  endfunction

  logic [XLEN-1:0] opb_eff;
  logic            rel_lt, rel_eq, rel_gt;

  always_comb begin
    opb_eff = use_imm ? widen(imm, is_signed) : opb;
    rel_lt  = less_than(opa, opb_eff, is_signed);
    rel_eq  = (opa == opb_eff);
    rel_gt  = !rel_lt && !rel_eq;
    nib     = make_nibble(rel_lt, rel_gt, rel_eq, so);
  end

  // R2: a relation nibble always names exactly one ordering
  a_r2_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(nib[FIELD_BITS-1:1]) == 1);

endmodule

// File: rtl/crb_field_file.sv
module crb_field_file #(
  parameter int NFIELD = 8,
  localparam int FB     = crb_pkg::FIELD_BITS,
  localparam int CRW    = FB * NFIELD,
  localparam int FLD_IW = $clog2(NFIELD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic [FLD_IW-1:0] cmp_fld,
  input  logic [FB-1:0]     cmp_nib,
  input  logic              rec_we,
  input  logic [FB-1:0]     rec_nib,
  output logic [CRW-1:0]    cr
);

  logic [NFIELD-1:0] fld_hit;

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    logic hit_cmp, hit_rec;
    assign hit_cmp    = cmp_we && (cmp_fld == FLD_IW'(f));
    assign hit_rec    = rec_we && (f == 0);
    assign fld_hit[f] = hit_cmp || hit_rec;

    always_ff @(posedge clk) begin
      if (!rst_n)       cr[CRW-1-FB*f -: FB] <= '0;
      else if (hit_cmp) cr[CRW-1-FB*f -: FB] <= cmp_nib;
      else if (hit_rec) cr[CRW-1-FB*f -: FB] <= rec_nib;
    end
  end

  // R12: without a compare or record write the register holds
  a_r12_cr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_we && !rec_we) |=> $stable(cr));

  // R5: at most one field is written by a compare
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_we |-> $onehot0(fld_hit));

  // R6: compare beats record when both aim at field 0
  a_r6_cmp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && rec_we && cmp_fld == '0) |=> cr[CRW-1 -: FB] == $past(cmp_nib));

endmodule

// File: rtl/crb_count_reg.sv
module crb_count_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [XLEN-1:0] ld_data,
  input  logic            dec_en,
  input  logic [XLEN-1:0] dec_val,
  output logic [XLEN-1:0] ctr
);

  logic dec_fire;
  assign dec_fire = dec_en && !ld_en;

  always_ff @(posedge clk) begin
    if (!rst_n)        ctr <= '0;
    else if (ld_en)    ctr <= ld_data;
    else if (dec_fire) ctr <= dec_val;
  end

  // R13: a load lands on the next edge regardless of a decrement
  a_r13_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ctr == $past(ld_data));

  // R9: a decrement lowers the count by exactly one
  a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> ctr == $past(ctr) - XLEN'(1));

  // R12: no load and no decrement keeps the count
  a_r12_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !dec_en) |=> $stable(ctr));

endmodule

// File: rtl/crb_decide.sv
module crb_decide #(
  parameter int XLEN   = 32,
  parameter int NFIELD = 8,
  localparam int CRW   = crb_pkg::FIELD_BITS * NFIELD,
  localparam int BIT_W = $clog2(CRW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [2:0]       mode,
  input  logic [BIT_W-1:0] bit_sel,
  input  logic             sense,
  input  logic [CRW-1:0]   cr,
  input  logic [XLEN-1:0]  ctr,
  output logic             taken,
  output logic             dec_req,
  output logic [XLEN-1:0]  ctr_minus
);
  import crb_pkg::*;

  br_mode_e         m;
  logic [BIT_W-1:0] idx;
  logic             cond_bit, cond_ok, ctr_zero, ctr_ok;

  always_comb begin
    m         = br_mode_e'(mode);
    idx       = BIT_W'(CRW - 1) - bit_sel;
    cond_bit  = cr[idx];
    cond_ok   = (cond_bit == sense);
    ctr_minus = ctr - XLEN'(1);
    ctr_zero  = (ctr_minus == '0);
    ctr_ok    = mode_wants_zero(m) ? ctr_zero : !ctr_zero;
    dec_req   = valid && mode_decrements(m);
    taken     = 1'b0;
    if (valid) begin
      unique case (m)
        BR_COND:                taken = cond_ok;
        BR_ALWAYS:              taken = 1'b1;
        BR_DNZ, BR_DZ:          taken = ctr_ok;
        BR_DNZ_COND, BR_DZ_COND: taken = ctr_ok && cond_ok;
        BR_RSV6, BR_RSV7:       taken = 1'b0;
      endcase
    end
  end

  // R10: a zero-test branch is taken only from a count of one
  a_r10_zero_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_wants_zero(m) && taken) |-> ctr == XLEN'(1));

  // R11: a combined form is never taken against its condition bit
  a_r11_bit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && mode_uses_bit(m)) |-> cr[idx] == sense);

  // R8: no request, no decision
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !taken && !dec_req);

endmodule

// File: rtl/cr_branch_unit.sv
module cr_branch_unit #(
  parameter int XLEN    = 32,
  parameter int NFIELD  = 8,
  parameter int IMMW    = 16,
  localparam int CRW    = crb_pkg::FIELD_BITS * NFIELD,
  localparam int FLD_IW = $clog2(NFIELD),
  localparam int BIT_W  = $clog2(CRW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              cmp_signed,
  input  logic              cmp_use_imm,
  input  logic [FLD_IW-1:0] cmp_field,
  input  logic [XLEN-1:0]   cmp_a,
  input  logic [XLEN-1:0]   cmp_b,
  input  logic [IMMW-1:0]   cmp_imm,
  input  logic              so_in,
  input  logic              rec_valid,
  input  logic [XLEN-1:0]   rec_result,
  input  logic              br_valid,
  input  logic [2:0]        br_mode,
  input  logic [BIT_W-1:0]  br_bit,
  input  logic              br_sense,
  input  logic              ctr_wr,
  input  logic [XLEN-1:0]   ctr_wdata,
  output logic              br_taken,
  output logic [CRW-1:0]    cr_value,
  output logic [XLEN-1:0]   ctr_value
);
  import crb_pkg::*;

  logic [FIELD_BITS-1:0] cmp_nib, rec_nib;
  logic                  dec_req;
  logic [XLEN-1:0]       ctr_minus;

  crb_compare #(.XLEN(XLEN), .IMMW(IMMW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .req(cmp_valid),
    .is_signed(cmp_signed), .use_imm(cmp_use_imm),
    .opa(cmp_a), .opb(cmp_b), .imm(cmp_imm), .so(so_in), .nib(cmp_nib));

  // record form: signed compare of the result against zero
  crb_compare #(.XLEN(XLEN), .IMMW(IMMW)) u_rec (
    .clk(clk), .rst_n(rst_n), .req(rec_valid),
    .is_signed(1'b1), .use_imm(1'b1),
    .opa(rec_result), .opb('0), .imm('0), .so(so_in), .nib(rec_nib));

  crb_field_file #(.NFIELD(NFIELD)) u_cr (
    .clk(clk), .rst_n(rst_n),
    .cmp_we(cmp_valid), .cmp_fld(cmp_field), .cmp_nib(cmp_nib),
    .rec_we(rec_valid), .rec_nib(rec_nib), .cr(cr_value));

  crb_decide #(.XLEN(XLEN), .NFIELD(NFIELD)) u_dec (
    .clk(clk), .rst_n(rst_n), .valid(br_valid), .mode(br_mode),
    .bit_sel(br_bit), .sense(br_sense), .cr(cr_value), .ctr(ctr_value),
    .taken(br_taken), .dec_req(dec_req), .ctr_minus(ctr_minus));

  crb_count_reg #(.XLEN(XLEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_en(ctr_wr), .ld_data(ctr_wdata),
    .dec_en(dec_req), .dec_val(ctr_minus), .ctr(ctr_value));

  // R7: a written field carries the overflow input of its cycle
  a_r7_so_copied: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !cmp_valid) |=> cr_value[CRW-FIELD_BITS] == $past(so_in));

endmodule

// File: tb/sim_cr_branch_unit.sv
`timescale 1ns/1ps
module sim_cr_branch_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmp_valid, cmp_signed, cmp_use_imm, so_in, rec_valid;
  logic [2:0]  cmp_field, br_mode;
  logic [31:0] cmp_a, cmp_b, rec_result, ctr_wdata;
  logic [15:0] cmp_imm;
  logic        br_valid, br_sense, ctr_wr, br_taken;
  logic [4:0]  br_bit;
  logic [31:0] cr_value, ctr_value;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_cr = '0;

  always #2 clk = ~clk;

  cr_branch_unit u0 (.*);

  // {signed, use_imm, field, so, a, b, imm, expected nibble LT GT EQ SO}
  localparam int VW = 1+1+3+1+32+32+16+4;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b0,3'd0,1'b0,32'd5,        32'd7,        16'h0000,4'h8}, // R2 signed less
    {1'b1,1'b0,3'd1,1'b0,32'hFFFF_FFFF,32'd1,        16'h0000,4'h8}, // R2 negative
    {1'b0,1'b0,3'd2,1'b0,32'hFFFF_FFFF,32'd1,        16'h0000,4'h4}, // R3 unsigned big
    {1'b0,1'b0,3'd3,1'b1,32'd1234,     32'd1234,     16'h0000,4'h3}, // R3 eq, R7 so
    {1'b1,1'b1,3'd4,1'b0,32'hFFFF_FFFF,32'd0,        16'hFFFF,4'h2}, // R4 sign-extend
    {1'b0,1'b1,3'd5,1'b0,32'hFFFF_FFFF,32'd0,        16'hFFFF,4'h4}, // R4 zero-extend
    {1'b1,1'b1,3'd6,1'b0,32'd0,        32'd0,        16'h8000,4'h4}, // R4 most negative imm
    {1'b0,1'b1,3'd7,1'b1,32'h0000_7FFF,32'd0,        16'h8000,4'h9}, // R4 unsigned, R7
    {1'b1,1'b0,3'd7,1'b0,32'h8000_0000,32'h7FFF_FFFF,16'h0000,4'h8}, // R2 sign edge
    {1'b0,1'b0,3'd0,1'b0,32'h8000_0000,32'h7FFF_FFFF,16'h0000,4'h4}  // R3 sign edge
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    cmp_valid = 0; cmp_signed = 0; cmp_use_imm = 0; cmp_field = 0;
    cmp_a = 0; cmp_b = 0; cmp_imm = 0; so_in = 0;
    rec_valid = 0; rec_result = 0;
    br_valid = 0; br_mode = 0; br_bit = 0; br_sense = 0;
    ctr_wr = 0; ctr_wdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put_field(input int f, input logic [3:0] n);
    exp_cr[31-4*f -: 4] = n;
  endtask

  task automatic branch(input logic [2:0] m, input logic [4:0] b, input logic s,
                        input logic exp_t, input string req);
    br_valid = 1; br_mode = m; br_bit = b; br_sense = s;
    #0.5 chk(req, {31'd0, br_taken}, {31'd0, exp_t});
    tick(); quiet();
  endtask

  initial begin
    quiet();
    repeat (3) tick();
    // R1
    chk("R1 cr", cr_value, 32'd0);
    chk("R1 ctr", ctr_value, 32'd0);
    chk("R1 taken", {31'd0, br_taken}, 32'd0);
    rst_n = 1;
    tick();

    // table of compares: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      cmp_valid = 1; cmp_signed = v[89]; cmp_use_imm = v[88]; cmp_field = v[87:85];
      so_in = v[84]; cmp_a = v[83:52]; cmp_b = v[51:20]; cmp_imm = v[19:4];
      put_field(int'(v[87:85]), v[3:0]);
      tick(); quiet();
      chk("R5 compare vector", cr_value, exp_cr);
    end

    // R6 record form: negative result into field 0
    rec_valid = 1; rec_result = 32'hFFFF_FFFB; put_field(0, 4'h8);
    tick(); quiet(); chk("R6 record negative", cr_value, exp_cr);
    // R6 record positive with compare on field 3 the same cycle, R7 so
    rec_valid = 1; rec_result = 32'd9; so_in = 1;
    cmp_valid = 1; cmp_field = 3; cmp_a = 32'd4; cmp_b = 32'd4;
    put_field(0, 4'h5); put_field(3, 4'h3);
    tick(); quiet(); chk("R6 record and compare", cr_value, exp_cr);
    // R6 collision on field 0: compare wins
    rec_valid = 1; rec_result = 32'd0;
    cmp_valid = 1; cmp_field = 0; cmp_signed = 1; cmp_a = 32'd1; cmp_b = 32'd2;
    put_field(0, 4'h8);
    tick(); quiet(); chk("R6 compare wins", cr_value, exp_cr);

    // R8 condition bits: bit n is cr_value[31-n]
    branch(3'd0, 5'd0,  1'b1, exp_cr[31], "R8 bit0 true");
    branch(3'd0, 5'd1,  1'b1, exp_cr[30], "R8 bit1 true");
    branch(3'd0, 5'd1,  1'b0, !exp_cr[30], "R8 bit1 false");
    branch(3'd0, 5'd31, 1'b0, !exp_cr[0], "R8 bit31 false");
    branch(3'd1, 5'd0,  1'b0, 1'b1, "R8 always");
    branch(3'd6, 5'd0,  1'b1, 1'b0, "R8 reserved6");
    branch(3'd7, 5'd0,  1'b1, 1'b0, "R8 reserved7");
    chk("R12 cond modes keep ctr", ctr_value, 32'd0);

    // R13 load then R9 countdown with wrap
    ctr_wr = 1; ctr_wdata = 32'd3; tick(); quiet();
    chk("R13 load", ctr_value, 32'd3);
    branch(3'd2, 5'd0, 1'b0, 1'b1, "R9 dnz 3");
    chk("R9 count 2", ctr_value, 32'd2);
    branch(3'd2, 5'd0, 1'b0, 1'b1, "R9 dnz 2");
    branch(3'd2, 5'd0, 1'b0, 1'b0, "R9 dnz 1");
    chk("R9 count 0", ctr_value, 32'd0);
    branch(3'd2, 5'd0, 1'b0, 1'b1, "R9 dnz wrap");
    chk("R9 wrap", ctr_value, 32'hFFFF_FFFF);
    // R10
    branch(3'd3, 5'd0, 1'b0, 1'b0, "R10 dz big");
    ctr_wr = 1; ctr_wdata = 32'd1; tick(); quiet();
    branch(3'd3, 5'd0, 1'b0, 1'b1, "R10 dz one");
    chk("R10 count 0", ctr_value, 32'd0);
    // R11 combined forms
    ctr_wr = 1; ctr_wdata = 32'd1; tick(); quiet();
    branch(3'd5, 5'd0, exp_cr[31], 1'b1, "R11 dz cond match");
    ctr_wr = 1; ctr_wdata = 32'd5; tick(); quiet();
    branch(3'd4, 5'd0, !exp_cr[31], 1'b0, "R11 dnz cond miss");
    chk("R11 decrement anyway", ctr_value, 32'd4);
    branch(3'd4, 5'd0, exp_cr[31], 1'b1, "R11 dnz cond match");
    chk("R12 branches keep cr", cr_value, exp_cr);
    // R13 load beats decrement; decision on old count 3
    ctr_wr = 1; ctr_wdata = 32'd7;
    branch(3'd2, 5'd0, 1'b0, 1'b1, "R13 decision on old count");
    chk("R13 load wins", ctr_value, 32'd7);
    chk("R12 final cr", cr_value, exp_cr);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule